// File: doc/BRIEF.md
# Serial Converter Device-Side Port Emulator

This block stands in for the digital side of an eight-channel, 10-bit serial sampling converter, so that host logic which talks to such a converter can be exercised without the analog part. The host drives an active-low select, a serial clock and a serial data line into the block. The block answers on a serial data line with an output enable, so that a pad or a bus model can tri-state it. It also reports whether the emulated converter is currently tracking or holding.

The inputs are oversampled on a fast system clock. Every conversion occupies a slot of sixteen serial-clock cycles. Three of them are tracking and thirteen are hold/convert. At the switch into hold the block raises a one-cycle request carrying the channel the host selected. The sample value presented on a parallel input is captured at that moment and shifted out. The word the host shifts in during a slot sets the channel used by the following slot. One frame may chain any number of slots.

Top module: `sconv_device_port`

## Requirements
- R1: `dout_oe` is high only while the (synchronised) select is low; whenever `dout_oe` is low, `dout` is 0.
- R2: Serial-clock and data-in activity while select is high has no effect: no request, no phase change, and the stored channel is unchanged.
- R3: If select falls while the serial clock is high, the first later serial-clock falling edge is falling edge 1 of the slot.
- R4: If select falls while the serial clock is already low, the select fall itself counts as falling edge 1 of the slot.
- R5: `in_hold` is 0 after falling edges 1 to 3 of a slot and 1 from falling edge 4 through falling edge 16.
- R6: At falling edge 4 of each slot, `sample_req` is high for exactly one system-clock cycle, and `sample_data` is captured in that cycle.
- R7: Within a slot, the bit driven after falling edge k is 0 for k = 1..4, captured-sample bit (14−k) for k = 5..14 (so the most significant bit comes first), and 0 for k = 15 and 16.
- R8: In a frame of several slots, falling edge 17, 33, … starts a new slot in track, and hold and a new request follow on its fourth falling edge.
- R9: `din` is sampled on serial-clock rising edges, first bit = word bit 15. After the 16th rising edge of a slot, word bits 13..11 become `sample_chan`, which is used by the next slot's request.
- R10: After reset `sample_chan` is 0. When select rises before a word is complete, the partial word is dropped and `sample_chan` keeps its earlier value.
- R11: If select and the serial clock fall together, that is a single falling edge 1 of the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Host select, active low, asynchronous |
| sclk | input | 1 | Host serial clock, asynchronous |
| din | input | 1 | Host serial control data |
| sample_data | input | 10 | Sample value for the requested channel |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for `dout` (tri-state control) |
| in_hold | output | 1 | 1 in hold/convert, 0 in track or idle |
| sample_req | output | 1 | One-cycle request at the track-to-hold switch |
| sample_chan | output | 3 | Channel selected for the current request |

## Verification
Frames are opened three ways: select falling with the clock high, with the clock low, and with both falling together. Only the last two merge the select fall with the first falling edge, so an off-by-one start shows up as hold and the request landing one edge early or late. A four-slot frame with a different channel word in each slot separates correct slot wrap-around and next-slot channel use from a counter that stops at 16 or applies a word at once. Clock toggling while deselected, and a frame cut off after ten edges, separate real gating and discarding of partial words from logic that keeps counting.

// File: rtl/sconv_pkg.sv
// Package: shared constants of the emulated serial converter slot format.
// Assumes a fixed 16-cycle slot: 4 leading zero bits, 10 result bits, 2 trailing zeros.
package sconv_pkg;
    localparam int SLOT_CYCLES  = 16;                     // serial clocks per conversion slot
    localparam int LEAD_BITS    = 4;                      // leading zeros before the result
    localparam int RESULT_BITS  = 10;                     // width of a conversion result
    localparam int TRACK_FALLS  = 3;                      // falling edges spent in track
    localparam int CHAN_BITS    = 3;                      // width of the channel field
    localparam int CHAN_LSB_POS = 11;                     // lowest bit of the channel field
    localparam int IDX_W        = $clog2(SLOT_CYCLES);    // slot position counter width
endpackage

// File: rtl/sconv_sync.sv
// Module: multi-stage synchroniser for a bundle of asynchronous inputs.
// Assumes the inputs change slowly compared to clk; STAGES must be at least 1.
module sconv_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // capture the raw asynchronous inputs
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                // pass the value one stage further down the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sconv_slot_tracker.sv
// Module: turns synchronised select/serial-clock levels into edge events,
// counts falling edges inside a slot, and runs the track/hold phase.
// Assumes cs_s and sclk_s are already synchronised to clk. A select fall with
// the serial clock low is merged with the first falling edge of the slot.
module sconv_slot_tracker
    import sconv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_s,
    input  logic             sclk_s,
    output logic             fall_ev,
    output logic             rise_ev,
    output logic [IDX_W-1:0] fall_idx,
    output logic             in_hold,
    output logic             sample_req
);
    localparam logic [IDX_W-1:0] HOLD_IDX = IDX_W'(TRACK_FALLS);

    logic             cs_q;
    logic             sclk_q;
    logic             started;
    logic [IDX_W-1:0] fall_pos;
    logic             active;
    logic             cs_fall;

    // remember the previous synchronised levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b1;
        end else begin
            cs_q   <= cs_s;
            sclk_q <= sclk_s;
        end
    end

    // derive the frame-qualified clock edge events
    always_comb begin
        active  = !cs_s;
        cs_fall = cs_q && !cs_s;
        fall_ev = active && !sclk_s && (sclk_q || cs_fall);
        rise_ev = active && !cs_q && !sclk_q && sclk_s;
    end

    // position of the falling edge being handled now (0 = first of a slot)
    always_comb begin
        if (started) fall_idx = fall_pos + 1'b1;
        else         fall_idx = '0;
    end

    // advance the slot position on every falling edge inside a frame
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            started  <= 1'b0;
            fall_pos <= '0;
        end else if (fall_ev) begin
            started  <= 1'b1;
            fall_pos <= fall_idx;
        end
    end

    // track/hold phase and the request pulse at the switch into hold
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            in_hold    <= 1'b0;
            sample_req <= 1'b0;
        end else begin
            sample_req <= fall_ev && (fall_idx == HOLD_IDX);
            if (fall_ev && (fall_idx == '0))
                in_hold <= 1'b0;
            else if (fall_ev && (fall_idx == HOLD_IDX))
                in_hold <= 1'b1;
        end
    end

    AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_req |=> !sample_req); // R6
    AST_REQ_WITH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        sample_req |-> in_hold); // R5
    AST_DESELECT_LEAVES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (!in_hold && !sample_req)); // R2
    AST_EDGES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fall_ev && rise_ev)); // R3
endmodule

// File: rtl/sconv_ctl_rx.sv
// Module: shifts in the host control word on serial-clock rising edges and
// keeps the channel field of the last complete word.
// Assumes words arrive first bit = bit 15; a select rise drops a partial word.
module sconv_ctl_rx
    import sconv_pkg::*;
#(
    parameter int WORD_W = SLOT_CYCLES,
    parameter int CHAN_W = CHAN_BITS,
    parameter int CH_LSB = CHAN_LSB_POS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              din_s,
    input  logic              rise_ev,
    output logic [CHAN_W-1:0] chan
);
    localparam int SHR_W = CH_LSB + CHAN_W - 1;   // bits that still matter at word end
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    logic [SHR_W-1:0] shreg;
    logic [CNT_W-1:0] bit_cnt;
    logic             word_done;

    assign word_done = rise_ev && (bit_cnt == LAST_BIT);

    // collect incoming bits; a deselect clears the partial word
    always_ff @(posedge clk) begin
        if (!rst_n || cs_s) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (rise_ev) begin
            shreg   <= {shreg[SHR_W-2:0], din_s};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // commit the channel field once a full word has been received
    always_ff @(posedge clk) begin
        if (!rst_n)
            chan <= '0;
        else if (word_done)
            chan <= shreg[SHR_W-1 -: CHAN_W];
    end

    AST_CHAN_ONLY_AT_WORD_END: assert property (@(posedge clk) disable iff (!rst_n)
        !word_done |=> $stable(chan)); // R10
    AST_DESELECT_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (bit_cnt == '0)); // R10
endmodule

// File: rtl/sconv_tx.sv
// Module: captures the requested sample and drives the serial result bits,
// one bit per falling edge, in the fixed slot layout.
// Assumes sample_data is valid in the cycle sample_req is high.
module sconv_tx
    import sconv_pkg::*;
#(
    parameter int RES_W = RESULT_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_s,
    input  logic             fall_ev,
    input  logic [IDX_W-1:0] fall_idx,
    input  logic             sample_req,
    input  logic [RES_W-1:0] sample_data,
    output logic             dout,
    output logic             dout_oe
);
    localparam int SEL_W = (RES_W > 1) ? $clog2(RES_W) : 1;

    logic [RES_W-1:0] data_q;
    logic             bit_next;
    logic [SEL_W-1:0] sel;

    // hold the sample captured at the track-to-hold switch
    always_ff @(posedge clk) begin
        if (!rst_n)          data_q <= '0;
        else if (sample_req) data_q <= sample_data;
    end

    // choose the bit belonging to the current slot position
    always_comb begin
        int pos;
        pos      = LEAD_BITS + RES_W - 1 - int'(fall_idx);
        sel      = pos[SEL_W-1:0];
        bit_next = 1'b0;
        if (int'(fall_idx) >= LEAD_BITS && int'(fall_idx) < LEAD_BITS + RES_W)
            bit_next = data_q[sel];
    end

    // drive the serial line and its enable
    always_ff @(posedge clk) begin
        if (!rst_n || cs_s) begin
            dout    <= 1'b0;
            dout_oe <= 1'b0;
        end else begin
            dout_oe <= 1'b1;
            if (fall_ev) dout <= bit_next;
        end
    end

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> !dout); // R1
    AST_DATA_HELD_OUTSIDE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sample_req) |-> $stable(data_q)); // R6
endmodule

// File: rtl/sconv_device_port.sv
// Module: top of the device-side serial converter emulator. Synchronises the
// host lines, tracks slots and phase, receives channel words, and serialises
// the requested samples.
// Assumes clk is at least 8x faster than the serial clock.
module sconv_device_port
    import sconv_pkg::*;
#(
    parameter int RES_W       = RESULT_BITS,
    parameter int CHAN_W      = CHAN_BITS,
    parameter int WORD_W      = SLOT_CYCLES,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    input  logic [RES_W-1:0]  sample_data,
    output logic              dout,
    output logic              dout_oe,
    output logic              in_hold,
    output logic              sample_req,
    output logic [CHAN_W-1:0] sample_chan
);
    logic [2:0]       sync_q;
    logic             cs_s;
    logic             sclk_s;
    logic             din_s;
    logic             fall_ev;
    logic             rise_ev;
    logic [IDX_W-1:0] fall_idx;

    sconv_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sclk, din}),
        .q     (sync_q)
    );

    assign cs_s   = sync_q[2];
    assign sclk_s = sync_q[1];
    assign din_s  = sync_q[0];

    sconv_slot_tracker u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_s       (cs_s),
        .sclk_s     (sclk_s),
        .fall_ev    (fall_ev),
        .rise_ev    (rise_ev),
        .fall_idx   (fall_idx),
        .in_hold    (in_hold),
        .sample_req (sample_req)
    );

    sconv_ctl_rx #(.WORD_W(WORD_W), .CHAN_W(CHAN_W), .CH_LSB(CHAN_LSB_POS)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_s    (cs_s),
        .din_s   (din_s),
        .rise_ev (rise_ev),
        .chan    (sample_chan)
    );

    sconv_tx #(.RES_W(RES_W)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_s        (cs_s),
        .fall_ev     (fall_ev),
        .fall_idx    (fall_idx),
        .sample_req  (sample_req),
        .sample_data (sample_data),
        .dout        (dout),
        .dout_oe     (dout_oe)
    );

    AST_TRACK_OUTPUTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !in_hold |-> !dout); // R7
    AST_HOLD_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_hold |-> dout_oe); // R1
endmodule

// File: tb/sconv_device_port_test.sv
// Bench: directed host-side scenarios against the converter port emulator.
module sconv_device_port_test;
    localparam int H = 8;   // system clocks per serial-clock half period

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b1;
    logic       din = 1'b0;
    logic [9:0] sample_data;
    logic       dout, dout_oe, in_hold, sample_req;
    logic [2:0] sample_chan;

    int         checks = 0;
    int         errors = 0;
    int         req_cnt = 0;
    logic [2:0] last_req_chan = '0;
    logic [2:0] model_chan = '0;
    logic [15:0] ctl_w [4];
    bit         done = 0;

    always #2 clk = ~clk;

    function automatic logic [9:0] val_of(input logic [2:0] c);
        return 10'h3A5 ^ {c, c, c, c[0]};
    endfunction

    assign sample_data = val_of(sample_chan);

    sconv_device_port uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .sample_data(sample_data), .dout(dout), .dout_oe(dout_oe),
        .in_hold(in_hold), .sample_req(sample_req), .sample_chan(sample_chan)
    );

    // record every request the block raises
    always @(posedge clk) begin
        if (rst_n && sample_req) begin
            req_cnt       <= req_cnt + 1;
            last_req_chan <= sample_chan;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_h();
        repeat (H) @(negedge clk);
    endtask

    function automatic logic [15:0] word_for(input logic [2:0] c);
        return 16'(c) << 11;
    endfunction

    // mode 0: select falls with clock high; 1: clock already low; 2: both together
    task automatic run_frame(input int nf, input int mode, input string tag);
        int         exp_req;
        logic [2:0] slot_chan;
        exp_req   = req_cnt;
        slot_chan = model_chan;
        din       = 1'b0;
        if (mode == 1) begin
            sclk = 1'b0; wait_h(); cs_n = 1'b0;
        end else if (mode == 2) begin
            sclk = 1'b1; wait_h(); cs_n = 1'b0; sclk = 1'b0;
        end else begin
            sclk = 1'b1; wait_h(); cs_n = 1'b0; wait_h();
            chk(dout_oe == 1'b1, "R1", "enable after select fall", dout_oe, 1);
            chk(in_hold == 1'b0, tag, "still track before first fall", in_hold, 0);
            sclk = 1'b0;
        end
        for (int g = 1; g <= nf; g++) begin
            int         k;
            int         slot;
            logic       exp_bit;
            k    = ((g - 1) % 16) + 1;
            slot = (g - 1) / 16;
            if (g > 1) sclk = 1'b0;
            din = ctl_w[slot][16 - k];
            if (k == 1) slot_chan = model_chan;
            if (k == 4) exp_req++;
            wait_h();
            chk(in_hold == (k >= 4), (slot == 0) ? tag : "R8",
                $sformatf("R5 phase after fall %0d", k), in_hold, int'(k >= 4));
            exp_bit = (k >= 5 && k <= 14) ? val_of(slot_chan)[14 - k] : 1'b0;
            chk(dout == exp_bit, (slot == 0) ? "R7" : "R8",
                $sformatf("data bit after fall %0d", k), dout, exp_bit);
            if (k == 4) begin
                chk(req_cnt == exp_req, "R6", "request count", req_cnt, exp_req);
                chk(last_req_chan == slot_chan, "R9",
                    $sformatf("request channel (%s)", tag), last_req_chan, slot_chan);
            end
            sclk = 1'b1;
            if (k == 16) model_chan = ctl_w[slot][13:11];
            wait_h();
        end
        cs_n = 1'b1;
        wait_h();
        chk(dout_oe == 1'b0 && dout == 1'b0, "R1", "line released after frame",
            {dout_oe, dout}, 0);
        chk(in_hold == 1'b0, "R1", "phase idle after frame", in_hold, 0);
        chk(req_cnt == exp_req, "R6", "requests in frame", req_cnt, exp_req);
    endtask

    task automatic t_reset();
        chk(dout_oe == 1'b0, "R1", "enable in reset state", dout_oe, 0);
        chk(in_hold == 1'b0 && sample_req == 1'b0, "R5", "phase/request at reset",
            {in_hold, sample_req}, 0);
        chk(sample_chan == 3'd0, "R10", "channel at reset", sample_chan, 0);
    endtask

    task automatic t_start_clock_high();
        ctl_w[0] = word_for(3'd5);
        run_frame(16, 0, "R3");
    endtask

    task automatic t_start_clock_low();
        ctl_w[0] = word_for(3'd2);
        run_frame(16, 1, "R4");
    endtask

    task automatic t_start_together();
        ctl_w[0] = word_for(3'd6);
        run_frame(16, 2, "R11");
    endtask

    task automatic t_chained();
        ctl_w[0] = word_for(3'd7);
        ctl_w[1] = word_for(3'd1) | 16'hC7FF;
        ctl_w[2] = word_for(3'd4);
        ctl_w[3] = word_for(3'd3);
        run_frame(64, 0, "R8");
    endtask

    task automatic t_ignored_while_deselected();
        int start_req;
        start_req = req_cnt;
        cs_n = 1'b1;
        for (int i = 0; i < 40; i++) begin
            din  = i[0];
            sclk = ~sclk;
            wait_h();
        end
        chk(req_cnt == start_req, "R2", "no request while deselected", req_cnt, start_req);
        chk(dout_oe == 1'b0 && in_hold == 1'b0, "R2", "idle while deselected",
            {dout_oe, in_hold}, 0);
        chk(sample_chan == model_chan, "R2", "channel kept while deselected",
            sample_chan, model_chan);
        ctl_w[0] = word_for(3'd1);
        run_frame(16, 0, "R2");
    endtask

    task automatic t_partial_word();
        ctl_w[0] = 16'hFFFF;
        run_frame(10, 0, "R10");
        chk(sample_chan == model_chan, "R10", "partial word dropped",
            sample_chan, model_chan);
        ctl_w[0] = word_for(3'd0);
        run_frame(16, 1, "R10");
    endtask

    initial begin
        for (int i = 0; i < 4; i++) ctl_w[i] = '0;
        repeat (6) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_start_clock_high();
        t_start_clock_low();
        t_start_together();
        t_chained();
        t_ignored_while_deselected();
        t_partial_word();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule